// File: doc/BRIEF.md
# Edge-Interrupt GPIO Port

This block is an 8-bit general-purpose I/O port. Software controls it through a small synchronous register bus. Each bit is set on its own as an input or an output. The pad is modelled as three separate signals: an incoming level, an outgoing value and an output enable. Every pin is brought into the clock domain by a two-flop synchronizer. The synchronized level can always be read back, whatever the pin's direction.

Each pin also has a sticky interrupt flag. The flag is set by either a rising or a falling transition of the synchronized level, and a per-bit edge-select register chooses which. Software clears a flag by writing 0 to it and can force it by writing 1. A per-bit enable masks each flag. The single interrupt request is raised when any flag is both set and enabled.

Register map (3-bit address; reads are combinational on `bus_addr`; writes take effect at the clock edge where `bus_sel` and `bus_wr` are both high):

| Addr | Register | Access |
|------|----------|--------|
| 0 | synchronized pin level | read only |
| 1 | output value | read/write |
| 2 | direction (1 = output) | read/write |
| 3 | interrupt enable | read/write |
| 4 | edge select (0 = rising, 1 = falling) | read/write |
| 5 | interrupt flags | read/write |
| 6, 7 | unused, read as 0 | none |

Top module: `gpio_edge_port`

## Requirements
- R1: After reset, every register reads 0, `pin_oe` and `pin_out` are 0 and `irq` is low.
- R2: `pin_oe` equals the direction register (1 = output) and `pin_out` equals the output register. Both registers read back exactly what was last written, bit by bit and in any mix.
- R3: Address 0 returns the pin level delayed by two clock edges. A change is not visible after one edge and is visible after the second.
- R4: With edge-select bit 0, a rising transition of a pin sets its flag at address 5 one edge after the change becomes visible at address 0. A falling transition does not set it.
- R5: With edge-select bit 1, a falling transition sets the flag and a rising transition does not.
- R6: A flag stays set until software writes 0 to that bit. A write to address 5 loads the written value, so writing 1 sets a flag.
- R7: `irq` is high exactly when some bit has both its flag and its enable set.
- R8: Writing the edge-select register never sets a flag by itself while the pin is steady.
- R9: Writes to address 0 have no effect on the value read back there.
- R10: When a qualifying edge and a software write of 0 to the same flag take effect at the same clock edge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register bus select |
| bus_wr | input | 1 | Write strobe (with bus_sel) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| pin_in | input | 8 | Incoming pad levels (asynchronous) |
| pin_out | output | 8 | Outgoing pad values |
| pin_oe | output | 8 | Pad output enables |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench samples address 0 one edge and two edges after a pin change. A synchronizer that is too short or too long is caught by one of those two reads. Both edge polarities are driven under both edge-select settings, so a swapped polarity or a detector that fires on any toggle sets flags the bench expects to stay clear. The edge-select register is flipped while the pins are held steady, which exposes a detector built on the selected level rather than on a true transition. A software clear is timed to land on the same edge as a detected edge, so a clear that takes priority and loses the interrupt leaves a 0 where the bench expects a 1.

// File: rtl/gpio_edge_port.sv
module gpio_edge_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_sel,
  input  logic         bus_wr,
  input  logic [2:0]   bus_addr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic         irq
);
  localparam logic [2:0] A_LVL = 3'd0, A_OUT = 3'd1, A_DIR = 3'd2,
                         A_IE  = 3'd3, A_ESEL = 3'd4, A_FLG = 3'd5;

  logic [W-1:0] s1_q, lvl_q, prev_q;
  logic [W-1:0] out_q, dir_q, ie_q, esel_q, flag_q;
  logic [W-1:0] hit;
  logic         we;

  assign we  = bus_sel & bus_wr;
  assign hit = (esel_q & prev_q & ~lvl_q) | (~esel_q & ~prev_q & lvl_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '0;
      lvl_q  <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= pin_in;
      lvl_q  <= s1_q;
      prev_q <= lvl_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      dir_q  <= '0;
      ie_q   <= '0;
      esel_q <= '0;
      flag_q <= '0;
    end else begin
      if (we && bus_addr == A_OUT)  out_q  <= bus_wdata;
      if (we && bus_addr == A_DIR)  dir_q  <= bus_wdata;
      if (we && bus_addr == A_IE)   ie_q   <= bus_wdata;
      if (we && bus_addr == A_ESEL) esel_q <= bus_wdata;
      flag_q <= ((we && bus_addr == A_FLG) ? bus_wdata : flag_q) | hit;
    end
  end

  always_comb begin
    case (bus_addr)
      A_LVL:   bus_rdata = lvl_q;
      A_OUT:   bus_rdata = out_q;
      A_DIR:   bus_rdata = dir_q;
      A_IE:    bus_rdata = ie_q;
      A_ESEL:  bus_rdata = esel_q;
      A_FLG:   bus_rdata = flag_q;
      default: bus_rdata = '0;
    endcase
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
  assign irq     = |(flag_q & ie_q);
endmodule

module gpio_edge_port_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         bus_sel,
  input logic         bus_wr,
  input logic [2:0]   bus_addr,
  input logic [W-1:0] bus_wdata,
  input logic [W-1:0] pin_oe,
  input logic         irq,
  input logic [W-1:0] flag_q,
  input logic [W-1:0] lvl_q,
  input logic [W-1:0] prev_q
);
  logic wr_flg, wr_dir, wr_ie;
  assign wr_flg = bus_sel && bus_wr && bus_addr == 3'd5;
  assign wr_dir = bus_sel && bus_wr && bus_addr == 3'd2;
  assign wr_ie  = bus_sel && bus_wr && bus_addr == 3'd3;

  p_dir_oe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> pin_oe == $past(bus_wdata));

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_flg |=> (flag_q & $past(flag_q)) == $past(flag_q));

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_flg && bus_wdata == '0 && lvl_q == prev_q) |=> flag_q == '0);

  p_irq_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ie && bus_wdata == '0) |=> !irq);

  p_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_flg && lvl_q == prev_q) |=> flag_q == $past(flag_q));
endmodule

bind gpio_edge_port gpio_edge_port_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pin_oe(pin_oe), .irq(irq),
  .flag_q(flag_q), .lvl_q(lvl_q), .prev_q(prev_q)
);

// File: tb/gpio_edge_port_test.sv
module gpio_edge_port_test;
  logic       clk = 0, rst_n = 0;
  logic       bus_sel = 0, bus_wr = 0;
  logic [2:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata, pin_in = 0, pin_out, pin_oe;
  logic       irq;
  int checks = 0, errors = 0;
  bit done = 0;

  localparam logic [15:0] VEC [0:3] = '{16'hFF00, 16'h0FF0, 16'hA55A, 16'h3CC3};

  gpio_edge_port uut (.*);

  always #4 clk = ~clk;

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic edges(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [7:0] v;
    edges(2); rst_n = 1; @(negedge clk);
    for (int a = 0; a < 8; a++) begin rd(a[2:0], v); chk("R1 reg", v, 8'h00); end
    chk("R1 oe", pin_oe, 0); chk("R1 out", pin_out, 0); chk("R1 irq", {7'b0, irq}, 0);

    for (int i = 0; i < 4; i++) begin
      wr(3'd2, VEC[i][15:8]); wr(3'd1, VEC[i][7:0]);
      chk("R2 oe", pin_oe, VEC[i][15:8]); chk("R2 out", pin_out, VEC[i][7:0]);
      rd(3'd2, v); chk("R2 dir rb", v, VEC[i][15:8]);
      rd(3'd1, v); chk("R2 out rb", v, VEC[i][7:0]);
    end
    wr(3'd2, 8'h00);

    pin_in = 8'hA5;
    edges(1); rd(3'd0, v); chk("R3 one edge", v, 8'h00);
    edges(1); rd(3'd0, v); chk("R3 two edges", v, 8'hA5);
    rd(3'd5, v); chk("R4 not yet", v, 8'h00);
    edges(1); rd(3'd5, v); chk("R4 rising", v, 8'hA5);
    wr(3'd5, 8'h00); rd(3'd5, v); chk("R6 clear", v, 8'h00);
    pin_in = 8'h00; edges(4); rd(3'd5, v); chk("R4 falling ignored", v, 8'h00);

    wr(3'd4, 8'hFF);
    pin_in = 8'h0F; edges(4); rd(3'd5, v); chk("R5 rising ignored", v, 8'h00);
    pin_in = 8'h00; edges(4); rd(3'd5, v); chk("R5 falling", v, 8'h0F);
    edges(10); rd(3'd5, v); chk("R6 sticky", v, 8'h0F);
    wr(3'd5, 8'hF0); rd(3'd5, v); chk("R6 load", v, 8'hF0);

    wr(3'd3, 8'h00); chk("R7 none", {7'b0, irq}, 0);
    wr(3'd3, 8'h01); chk("R7 masked", {7'b0, irq}, 0);
    wr(3'd3, 8'h10); chk("R7 hit", {7'b0, irq}, 1);
    wr(3'd5, 8'h00); chk("R7 cleared", {7'b0, irq}, 0);

    wr(3'd4, 8'h00); edges(3); rd(3'd5, v); chk("R8 to rising", v, 8'h00);
    pin_in = 8'hFF; edges(4); rd(3'd5, v); chk("R8 setup", v, 8'hFF);
    wr(3'd5, 8'h00);
    wr(3'd4, 8'hFF); edges(3); rd(3'd5, v); chk("R8 to falling", v, 8'h00);

    wr(3'd0, 8'h3C); rd(3'd0, v); chk("R9 level", v, 8'hFF);

    pin_in = 8'h00;
    @(posedge clk); @(posedge clk); @(negedge clk);
    wr(3'd5, 8'h00); rd(3'd5, v); chk("R10 set wins", v, 8'hFF);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (5000) @(posedge clk); checks++; errors++;
        $display("FAIL watchdog actual=running expected=done"); end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule